// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Flags and Read Rewind

This block is a single-clock FIFO with a 36-bit data path and a power-of-two depth set by a parameter. A mode input is sampled while reset is held and picks one of two read-side behaviours. In standard mode a read strobe loads the oldest word into the output register. In fall-through mode the oldest word is already waiting on the output, and a read strobe moves on to the next word. The same two flag pins report emptiness and fullness in standard mode. In fall-through mode they report that output data is valid and that a write has room.

The block also drives a half-full flag and two threshold flags, both active low. The two thresholds come in on offset inputs that are driven by a separate offset register block. A mark strobe saves the current read position. A retransmit strobe later moves the read pointer back to that saved position, so the same data can be read out again. All FIFO traffic is accepted only while the load-enable input is high.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rstN` is low, both pointers and the mark position are cleared and `rdData` becomes all zeros. After reset in standard mode, `rdFlag`=1, `wrFlag`=0, `halfFull`=0 and `almostFullN`=1.
- R2: The read-side mode is taken from `fwftSel` only while reset is held (0 = standard, 1 = fall-through). Changing `fwftSel` after reset has no effect.
- R3: In standard mode, a read on a non-empty FIFO puts the oldest word on `rdData` after that clock edge, in write order. `rdFlag` is 1 exactly when the FIFO holds zero words, and `wrFlag` is 1 exactly when it holds DEPTH words.
- R4: In fall-through mode, the oldest stored word is on `rdData` after the edge that wrote it or exposed it, with no read strobe. A read discards it. `rdFlag` is 1 when at least one word is held. `wrFlag` is 1 when fewer than DEPTH words are held. When the FIFO runs empty, `rdData` keeps the last word it showed.
- R5: A write while full and a read while empty are ignored. The count and the data do not change.
- R6: `halfFull` is 1 exactly when the count is strictly greater than DEPTH/2.
- R7: `almostEmptyN` is 0 when the count is less than `emptyOffset`, and 1 otherwise.
- R8: `almostFullN` is 0 when the number of free words (DEPTH minus the count) is less than or equal to `fullOffset`, and 1 otherwise.
- R9: While `loadEn` is 0, writes, reads, mark and retransmit have no effect.
- R10: `mark` saves the read position as it stands before any read in the same cycle. `retransmit` restores the read pointer to that position, so the count becomes the number of words written since the mark position. A read in the same cycle as `retransmit` is ignored. The flags show the new count after that edge.
- R11: A read and a write in the same cycle on a FIFO that is neither empty nor full both take effect, and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous master reset, active low |
| fwftSel | input | 1 | Read-mode select, sampled during reset (1 = fall-through) |
| loadEn | input | 1 | Must be 1 for FIFO traffic, mark or retransmit to be accepted |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Output data register |
| mark | input | 1 | Save the current read position |
| retransmit | input | 1 | Restore the read pointer to the saved position |
| emptyOffset | input | log2(DEPTH)+1 | Almost-empty threshold |
| fullOffset | input | log2(DEPTH)+1 | Almost-full threshold, counted in free words |
| rdFlag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| wrFlag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| halfFull | output | 1 | Count is above DEPTH/2 |
| almostEmptyN | output | 1 | Active-low almost-empty flag |
| almostFullN | output | 1 | Active-low almost-full flag |

## Verification
The bench builds the FIFO with DEPTH set to 8. With that depth, full, the half-full boundary between 4 and 5 words, and both threshold crossings are reached within a few cycles. The offsets are driven at run time, which moves the threshold edges to chosen counts. Each mode gets its own reset, so the fall-through path, the retransmit rewind and the gating by load-enable are each tested from a known empty state.

// File: rtl/pff_pkg.sv
package pff_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic wrDo;     // write wrData into the array at wrAddr
    logic loadOut;  // load the output register
    logic bypass;   // load the output register from wrData instead of the array
  } dpStrobe_t;
endpackage

// File: rtl/pff_ctrl.sv
module pff_ctrl
  import pff_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fwftSel,
  input  logic          loadEn,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          markIn,
  input  logic          retxIn,
  input  logic [CW-1:0] emptyOffset,
  input  logic [CW-1:0] fullOffset,
  output dpStrobe_t     strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fwftMode,
  output logic [CW-1:0] occ,
  output logic          rdFlag,
  output logic          wrFlag,
  output logic          halfFull,
  output logic          almostEmptyN,
  output logic          almostFullN
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  // The pointers carry one extra wrap bit, so occupancy is a plain subtraction
  logic [CW-1:0] wrPtr, rdPtr, markPtr;
  logic [CW-1:0] wrPtrNext, rdPtrNext, occNext, freeCnt;
  logic isEmpty, isFull, wrDo, rdDo, retxDo, markDo;

  always_comb begin
    occ      = wrPtr - rdPtr;
    freeCnt  = DEPTH_C - occ;
    isEmpty  = (occ == '0);
    isFull   = (occ == DEPTH_C);
    wrDo     = loadEn & wrEn & ~isFull;
    retxDo   = loadEn & retxIn;
    rdDo     = loadEn & rdEn & ~isEmpty & ~retxDo;
    markDo   = loadEn & markIn;
    wrPtrNext = wrPtr + CW'(wrDo);
    rdPtrNext = retxDo ? markPtr : (rdPtr + CW'(rdDo));
    occNext   = wrPtrNext - rdPtrNext;
  end

  // Strobes to the datapath; the read mode picks how the output register is fed
  always_comb begin
    strobe.wrDo = wrDo;
    wrAddr      = wrPtr[AW-1:0];
    if (fwftMode) begin
      // The register always holds the head as it will be after this edge
      strobe.loadOut = (occNext != '0);
      strobe.bypass  = wrDo & (wrPtr == rdPtrNext);
      rdAddr         = rdPtrNext[AW-1:0];
    end else begin
      strobe.loadOut = rdDo;
      strobe.bypass  = 1'b0;
      rdAddr         = rdPtr[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      markPtr  <= '0;
      fwftMode <= fwftSel;
    end else begin
      wrPtr <= wrPtrNext;
      rdPtr <= rdPtrNext;
      if (markDo) markPtr <= rdPtr;
    end
  end

  // Flags follow the registered pointers
  always_comb begin
    rdFlag       = fwftMode ? ~isEmpty : isEmpty;
    wrFlag       = fwftMode ? ~isFull  : isFull;
    halfFull     = (occ > HALF_C);
    almostEmptyN = ~(occ < emptyOffset);
    almostFullN  = ~(freeCnt <= fullOffset);
  end
endmodule

// File: rtl/pff_dpath.sv
module pff_dpath
  import pff_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrDo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.loadOut) rdData <= strobe.bypass ? wrData : store[rdAddr];
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              loadEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              mark,
  input  logic              retransmit,
  input  logic [CW-1:0]     emptyOffset,
  input  logic [CW-1:0]     fullOffset,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              halfFull,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  dpStrobe_t     strobe;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftMode;
  logic [CW-1:0] occ;

  pff_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .fwftSel(fwftSel), .loadEn(loadEn),
    .wrEn(wrEn), .rdEn(rdEn), .markIn(mark), .retxIn(retransmit),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fwftMode(fwftMode), .occ(occ),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  pff_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic              wrEn,
  input logic              rdEn,
  input logic              retransmit,
  input logic              fwftMode,
  input logic [CW-1:0]     occ,
  input logic [DATA_W-1:0] rdData,
  input logic              rdFlag,
  input logic              wrFlag,
  input logic              halfFull,
  input logic              almostFullN
);
  // R5: a write into a full FIFO in standard mode leaves it full
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (!fwftMode && wrFlag && wrEn && !rdEn && !retransmit) |=> wrFlag);

  // R5: a read from an empty FIFO in standard mode keeps it empty and keeps the data
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (!fwftMode && rdFlag && rdEn && !wrEn && !retransmit) |=> (rdFlag && $stable(rdData)));

  // R8: with no free words the almost-full flag is asserted for any offset
  a_r8_full_is_almost_full: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CW'(DEPTH)) |-> !almostFullN);

  // R9: without load enable nothing visible moves
  a_r9_hold_when_unloaded: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ($stable(rdData) && $stable(rdFlag) && $stable(wrFlag) && $stable(halfFull)));

  // R6: half-full can only rise after a write or a retransmit
  a_r6_half_rises_on_fill: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfFull) |-> ($past(wrEn) || $past(retransmit)));
endmodule

bind prog_flag_fifo pff_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) checker_i (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .wrEn(wrEn), .rdEn(rdEn),
  .retransmit(retransmit), .fwftMode(fwftMode), .occ(occ), .rdData(rdData),
  .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull), .almostFullN(almostFullN)
);

// File: tb/prog_flag_fifo_tb_top.sv
module prog_flag_fifo_tb_top;
  localparam int DW = 36;
  localparam int DEP = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN, fwftSel, loadEn, wrEn, rdEn, mark, retransmit;
  logic [DW-1:0] wrData, rdData;
  logic [CW-1:0] emptyOffset, fullOffset;
  logic rdFlag, wrFlag, halfFull, almostEmptyN, almostFullN;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rstN(rstN), .fwftSel(fwftSel), .loadEn(loadEn),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .mark(mark), .retransmit(retransmit),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  // Standard-mode stimulus table: {write, read, expected count after the edge}
  localparam int NVEC = 21;
  localparam logic [5:0] VEC [NVEC] = '{
    {2'b10, 4'd1}, {2'b10, 4'd2}, {2'b10, 4'd3}, {2'b10, 4'd4}, {2'b10, 4'd5},
    {2'b11, 4'd5}, {2'b10, 4'd6}, {2'b10, 4'd7}, {2'b10, 4'd8}, {2'b10, 4'd8},
    {2'b11, 4'd7}, {2'b01, 4'd6}, {2'b01, 4'd5}, {2'b01, 4'd4}, {2'b01, 4'd3},
    {2'b01, 4'd2}, {2'b01, 4'd1}, {2'b01, 4'd0}, {2'b01, 4'd0}, {2'b11, 4'd1},
    {2'b01, 4'd0}
  };

  function automatic logic [DW-1:0] pat(input int n);
    return {4'(n), 32'hC0DE_0000 + 32'(n)};
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; mark = 0; retransmit = 0;
  endtask

  task automatic doReset(input logic mode);
    rstN = 0; fwftSel = mode; loadEn = 1; idle(); wrData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // One clock with the given strobes; returns at the falling edge after it
  task automatic cyc(input logic w, input logic r, input logic mk, input logic rt,
                     input logic [DW-1:0] d);
    wrEn = w; rdEn = r; mark = mk; retransmit = rt; wrData = d;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // Standard-mode flag expectations from a count
  task automatic stdFlags(input int cnt, input int eOff, input int fOff, input string tag);
    check(DW'(rdFlag), DW'(cnt == 0), {tag, " R3 rdFlag(empty)"});
    check(DW'(wrFlag), DW'(cnt == DEP), {tag, " R3 wrFlag(full)"});
    check(DW'(halfFull), DW'(cnt > DEP / 2), {tag, " R6 halfFull"});
    check(DW'(almostEmptyN), DW'(!(cnt < eOff)), {tag, " R7 almostEmptyN"});
    check(DW'(almostFullN), DW'(!((DEP - cnt) <= fOff)), {tag, " R8 almostFullN"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q[$];
    logic [DW-1:0] lastOut;
    int n;
    emptyOffset = 4'd2; fullOffset = 4'd2;

    // R1: reset state
    doReset(1'b0);
    check(rdData, '0, "R1 rdData cleared");
    stdFlags(0, 2, 2, "R1");

    // Table walk, standard mode (R3 R5 R6 R7 R8 R11)
    lastOut = '0; n = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic w, r, wOk, rOk;
      int cnt;
      w = VEC[i][5]; r = VEC[i][4]; cnt = int'(VEC[i][3:0]);
      wOk = w && (q.size() < DEP);
      rOk = r && (q.size() > 0);
      cyc(w, r, 1'b0, 1'b0, pat(n));
      if (rOk) lastOut = q.pop_front();
      if (wOk) q.push_back(pat(n));
      n++;
      check(rdData, lastOut, $sformatf("vec %0d R3/R5/R11 rdData", i));
      stdFlags(cnt, 2, 2, $sformatf("vec %0d", i));
    end

    // R7: a zero offset never flags almost-empty, even when empty
    emptyOffset = 4'd0;
    #1 check(DW'(almostEmptyN), DW'(1), "R7 offset zero");
    emptyOffset = 4'd2;

    // R2: fwftSel raised after reset does not switch the mode
    fwftSel = 1;
    cyc(1, 0, 0, 0, pat(100));
    check(DW'(rdFlag), DW'(0), "R2 still standard, rdFlag not ready-meaning");
    check(rdData, lastOut, "R2 no fall-through");
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(100), "R2 read returns word");

    // R9: load enable low blocks everything
    doReset(1'b0);
    loadEn = 0;
    cyc(1, 0, 0, 0, pat(200));
    check(DW'(rdFlag), DW'(1), "R9 write ignored");
    loadEn = 1;
    cyc(1, 0, 0, 0, pat(201));
    loadEn = 0;
    cyc(0, 1, 0, 0, '0);
    check(rdData, '0, "R9 read ignored");
    check(DW'(rdFlag), DW'(0), "R9 count kept");
    loadEn = 1;
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(201), "R9 word intact");

    // R10: mark and retransmit
    doReset(1'b0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, pat(300 + k));
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(300), "R10 first read");
    cyc(0, 0, 1, 0, '0);
    cyc(0, 1, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(302), "R10 drained");
    check(DW'(rdFlag), DW'(1), "R10 empty before rewind");
    cyc(0, 0, 0, 1, '0);
    check(DW'(rdFlag), DW'(0), "R10 rewind restores count");
    check(DW'(almostEmptyN), DW'(1), "R10 count two reaches offset");
    check(rdData, pat(302), "R10 rewind leaves output");
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(301), "R10 reread marked word");
    cyc(0, 1, 0, 1, '0);
    check(rdData, pat(301), "R10 read beside retransmit ignored");
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(301), "R10 second rewind");
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(302), "R10 order after rewind");
    check(DW'(rdFlag), DW'(1), "R10 empty again");

    // R4: fall-through mode
    doReset(1'b1);
    check(DW'(rdFlag), DW'(0), "R4 not ready after reset");
    check(DW'(wrFlag), DW'(1), "R4 room after reset");
    cyc(1, 0, 0, 0, pat(400));
    check(rdData, pat(400), "R4 first word falls through");
    check(DW'(rdFlag), DW'(1), "R4 ready");
    cyc(1, 0, 0, 0, pat(401));
    check(rdData, pat(400), "R4 head held");
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(401), "R4 read exposes next");
    cyc(0, 1, 0, 0, '0);
    check(DW'(rdFlag), DW'(0), "R4 empty, not ready");
    check(rdData, pat(401), "R4 last word kept");
    for (int k = 0; k < DEP; k++) cyc(1, 0, 0, 0, pat(410 + k));
    check(rdData, pat(410), "R4 head after fill");
    check(DW'(wrFlag), DW'(0), "R4 no room when full");
    cyc(1, 0, 0, 0, pat(499));
    cyc(0, 1, 0, 0, '0);
    check(rdData, pat(411), "R4/R5 overflow word dropped");
    check(DW'(wrFlag), DW'(1), "R4 room after read");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule